// File: doc/BRIEF.md
# Synthesizer Serial Command Responder

This block is the device end of a byte-oriented command link for a two-channel frequency synthesizer. Bytes arrive from a UART receiver as single-cycle valid strobes. Replies leave through a valid/ready byte port toward a UART transmitter. The first byte of each command is an opcode. Bit 7 of the opcode marks a read and bit 3 picks the channel. A write carries a fixed-length payload and a trailing checksum, and the block answers it with a single acknowledge or reject code. A read is answered right away with the requested bytes and a checksum.

Behind the parser sits a byte-wide settings store. For each channel it holds six 32-bit PLL control words, a VCO range pair and a text label. A reference-frequency word is shared by both channels, and a separate flag selects the external reference. Writes pass through a staging buffer and reach the store only after the checksum has been verified, so a damaged frame leaves no trace. A store-to-non-volatile request is handed on as a one-cycle pulse. The lock indicators of the two PLLs are resynchronised and reported in a status byte.

Top module: `synth_cmd_responder`

## Requirements
- R1: Opcode bit 7 set means read and clear means write. Opcode bit 3 set addresses channel B and clear addresses channel A. The two channels have separate storage.
- R2: Read opcode 0x80 (A) or 0x88 (B) replies with the 24 stored control-word bytes in the order they were written, then one checksum byte. The reply checksum is the modulo-256 sum of the reply's data bytes. The first reply byte is offered in the cycle after the opcode is accepted.
- R3: A write is the opcode, then its payload, then one checksum byte. The checksum equals the modulo-256 sum of the opcode and payload. When it matches, the payload is stored and the reply is 0x06, offered in the cycle after the checksum byte is accepted. Write opcodes 0x00/0x08 carry 24 bytes.
- R4: A write whose checksum does not match is answered with 0x15 and changes no stored value, no flag and no pulse.
- R5: Any opcode outside the table in R2, R3 and R6 to R9 is answered at once with 0x15 and changes nothing. This includes 0x09, 0x0E, 0x86 with channel B, and 0xC0.
- R6: Opcode 0x01 writes and opcode 0x81 reads the 4-byte shared reference-frequency word.
- R7: Opcode 0x06 with one payload byte sets the reference-select flag from payload bit 0. Opcode 0x86 returns one status byte and its checksum. In the status byte, bit 0 is the select flag, bit 5 is channel A lock, bit 4 is channel B lock, and all other bits are 0.
- R8: Opcodes 0x03/0x0B and 0x83/0x8B write and read the 4-byte VCO range of channel A/B. Opcodes 0x02/0x0A and 0x82/0x8A write and read the 16-byte label of channel A/B.
- R9: Opcode 0x40 followed by checksum 0x40 raises flash_store for exactly one cycle, in the same cycle as the 0x06 reply appears.
- R10: While a write is partly received, TIMEOUT_CYCLES consecutive cycles without a byte drop the command with no reply and no store change. Shorter gaps are tolerated.
- R11: lock_a and lock_b each pass through two flip-flops before they reach the status byte.
- R12: While tx_valid is high and tx_ready is low, tx_valid and tx_data hold. Bytes received while a reply is outstanding are discarded. No byte is sent that no command asked for.
- R13: After reset, every stored byte and the select flag are 0, tx_valid is low and flash_store is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe, one cycle per byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmitter accepts the reply byte |
| tx_data | output | 8 | Reply byte |
| lock_a | input | 1 | Channel A PLL lock, asynchronous |
| lock_b | input | 1 | Channel B PLL lock, asynchronous |
| flash_store | output | 1 | One-cycle request to save settings to non-volatile memory |

## Verification
A read reply must show its first byte in the cycle after the opcode is sampled. An acknowledge or reject must appear in the cycle after the checksum byte, or in the cycle after an unknown opcode. The flash pulse shares that cycle with the acknowledge. Reply bytes are then paced purely by tx_ready, and a lock change reaches the status byte two edges later. The bench drives every input a short delay after a rising edge and samples outputs at the falling edge. For acknowledges and the flash pulse, it checks the falling edge right after the last byte is sampled. Every offered byte is compared in arrival order against a queue that the driver filled from its own model before it sent the command, so a late, extra or missing byte is reported.

// File: rtl/synth_cmd_pkg.sv
package synth_cmd_pkg;

  typedef enum logic [2:0] {ST_OP, ST_PAY, ST_SUM, ST_DATA, ST_CODE} state_t;

  typedef enum logic [2:0] {K_NONE, K_SYN, K_REF, K_LBL, K_VCO, K_SEL, K_FLASH} kind_t;

  typedef struct packed {
    logic  rd;
    logic  chb;
    kind_t kind;
  } dec_t;

  localparam logic [7:0] CODE_ACK  = 8'h06;
  localparam logic [7:0] CODE_NACK = 8'h15;

  // Opcode bit 7 = read, bit 3 = channel; the other six bits name the item.
  function automatic dec_t decode_op(input logic [7:0] op);
    dec_t d;
    d.rd   = op[7];
    d.chb  = op[3];
    d.kind = K_NONE;
    case ({op[6:4], op[2:0]})
      6'h00: d.kind = K_SYN;
      6'h01: d.kind = op[3] ? K_NONE : K_REF;
      6'h02: d.kind = K_LBL;
      6'h03: d.kind = K_VCO;
      6'h06: d.kind = op[3] ? K_NONE : K_SEL;
      6'h20: d.kind = (op[3] || op[7]) ? K_NONE : K_FLASH;
      default: d.kind = K_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/synth_lock_sync.sv
module synth_lock_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = pipe[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '0;
      else        pipe[g] <= src;
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/synth_settings_store.sv
module synth_settings_store #(
  parameter int MEM_BYTES   = 92,
  parameter int STAGE_BYTES = 24,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int LW = $clog2(STAGE_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [AW-1:0]            commit_base,
  input  logic [LW-1:0]            commit_len,
  input  logic [STAGE_BYTES*8-1:0] stage,
  input  logic [AW-1:0]            rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     sel_we,
  input  logic                     sel_d,
  output logic                     sel_q
);
  logic [7:0] mem    [MEM_BYTES];
  logic       wr_en  [MEM_BYTES];
  logic [7:0] wr_byte[MEM_BYTES];

  always_comb begin
    for (int i = 0; i < MEM_BYTES; i++) begin
      wr_en[i]   = commit && (i >= int'(commit_base)) &&
                   (i < int'(commit_base) + int'(commit_len));
      wr_byte[i] = wr_en[i] ? stage[(i - int'(commit_base))*8 +: 8] : mem[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      sel_q <= 1'b0;
    end else begin
      for (int i = 0; i < MEM_BYTES; i++) if (wr_en[i]) mem[i] <= wr_byte[i];
      if (sel_we) sel_q <= sel_d;
    end
  end

  assign rd_data = (int'(rd_addr) < MEM_BYTES) ? mem[rd_addr] : 8'h00;
endmodule

// File: rtl/synth_cmd_responder.sv
module synth_cmd_responder
  import synth_cmd_pkg::*;
#(
  parameter int SYN_REGS       = 6,
  parameter int LABEL_BYTES    = 16,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  input  logic       lock_a,
  input  logic       lock_b,
  output logic       flash_store
);
  localparam int REG_BYTES   = SYN_REGS * 4;
  localparam int VCO_BYTES   = 4;
  localparam int REF_BYTES   = 4;
  localparam int CH_BYTES    = REG_BYTES + VCO_BYTES + LABEL_BYTES;
  localparam int MEM_BYTES   = 2 * CH_BYTES + REF_BYTES;
  localparam int STAGE_BYTES = (REG_BYTES > LABEL_BYTES) ? REG_BYTES : LABEL_BYTES;
  localparam int AW = $clog2(MEM_BYTES);
  localparam int LW = $clog2(STAGE_BYTES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  state_t state_q, state_d;
  kind_t  kind_q, kind_d;
  logic [AW-1:0] base_q, base_d, nb, ch_off;
  logic [LW-1:0] len_q, len_d, idx_q, idx_d, nl;
  logic [7:0]    sum_q, sum_d, code_q, code_d;
  logic [TW-1:0] timer_q, timer_d;
  logic [STAGE_BYTES*8-1:0] stage_q, stage_d;
  logic flash_q, flash_d, commit, sel_we, sel_q, stage_we;
  logic lock_a_s, lock_b_s, timeout_hit;
  logic [7:0] rd_data, status, data_byte;
  dec_t dec;

  synth_lock_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({lock_b, lock_a}), .q({lock_b_s, lock_a_s}));

  synth_settings_store #(.MEM_BYTES(MEM_BYTES), .STAGE_BYTES(STAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_base(base_q),
    .commit_len(len_q), .stage(stage_q), .rd_addr(base_q + AW'(idx_q)),
    .rd_data(rd_data), .sel_we(sel_we), .sel_d(stage_q[0]), .sel_q(sel_q));

  // Opcode decode into base address and length
  always_comb begin
    dec    = decode_op(rx_data);
    ch_off = dec.chb ? AW'(CH_BYTES) : '0;
    nb     = '0;
    nl     = '0;
    case (dec.kind)
      K_SYN:   begin nb = ch_off;                                nl = LW'(REG_BYTES);   end
      K_VCO:   begin nb = ch_off + AW'(REG_BYTES);               nl = LW'(VCO_BYTES);   end
      K_LBL:   begin nb = ch_off + AW'(REG_BYTES + VCO_BYTES);   nl = LW'(LABEL_BYTES); end
      K_REF:   begin nb = AW'(2 * CH_BYTES);                     nl = LW'(REF_BYTES);   end
      K_SEL:   nl = LW'(1);
      default: nl = '0;
    endcase
  end

  assign status      = {2'b00, lock_a_s, lock_b_s, 3'b000, sel_q};
  assign data_byte   = (kind_q == K_SEL) ? status : rd_data;
  assign timeout_hit = (timer_q == TW'(TIMEOUT_CYCLES - 1));

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    case (state_q)
      ST_DATA: begin tx_valid = 1'b1; tx_data = (idx_q == len_q) ? sum_q : data_byte; end
      ST_CODE: begin tx_valid = 1'b1; tx_data = code_q; end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q; kind_d = kind_q; base_d = base_q; len_d = len_q;
    idx_d = idx_q; sum_d = sum_q; code_d = code_q; timer_d = timer_q;
    stage_d = stage_q; stage_we = 1'b0; flash_d = 1'b0;
    commit = 1'b0; sel_we = 1'b0;
    case (state_q)
      ST_OP: if (rx_valid) begin
        kind_d = dec.kind; base_d = nb; len_d = nl;
        idx_d = '0; timer_d = '0; sum_d = rx_data;
        if (dec.kind == K_NONE) begin
          code_d = CODE_NACK; state_d = ST_CODE;
        end else if (dec.rd) begin
          sum_d = 8'h00; state_d = ST_DATA;
        end else begin
          state_d = (nl == '0) ? ST_SUM : ST_PAY;
        end
      end
      ST_PAY: if (rx_valid) begin
        stage_we = 1'b1;
        stage_d[int'(idx_q)*8 +: 8] = rx_data;
        sum_d = sum_q + rx_data; idx_d = idx_q + 1'b1; timer_d = '0;
        if (idx_q == len_q - 1'b1) state_d = ST_SUM;
      end else if (timeout_hit) begin
        state_d = ST_OP;
      end else begin
        timer_d = timer_q + 1'b1;
      end
      ST_SUM: if (rx_valid) begin
        state_d = ST_CODE; idx_d = '0;
        if (rx_data == sum_q) begin
          code_d = CODE_ACK;
          case (kind_q)
            K_SEL:   sel_we  = 1'b1;
            K_FLASH: flash_d = 1'b1;
            default: commit  = 1'b1;
          endcase
        end else begin
          code_d = CODE_NACK;
        end
      end else if (timeout_hit) begin
        state_d = ST_OP;
      end else begin
        timer_d = timer_q + 1'b1;
      end
      ST_DATA: if (tx_ready) begin
        sum_d = sum_q + tx_data; idx_d = idx_q + 1'b1;
        if (idx_q == len_q) state_d = ST_OP;
      end
      ST_CODE: if (tx_ready) state_d = ST_OP;
      default: state_d = ST_OP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OP;  kind_q <= K_NONE; base_q <= '0; len_q <= '0;
      idx_q <= '0; sum_q <= '0; code_q <= '0; timer_q <= '0; flash_q <= 1'b0;
    end else begin
      state_q <= state_d; kind_q <= kind_d; base_q <= base_d; len_q <= len_d;
      idx_q <= idx_d; sum_q <= sum_d; code_q <= code_d; timer_q <= timer_d;
      flash_q <= flash_d;
    end
  end

  always_ff @(posedge clk) begin
    if (stage_we) stage_q <= stage_d;
  end

  assign flash_store = flash_q;
endmodule

// File: rtl/synth_cmd_responder_chk.sv
module synth_cmd_responder_chk
  import synth_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       flash_store,
  input logic       lock_a,
  input logic       lock_a_s,
  input state_t     state
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R12

  AST_FLASH_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    flash_store |-> tx_valid && tx_data == 8'h06); // R9

  AST_FLASH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flash_store |=> !flash_store); // R9

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CODE |-> tx_data == 8'h06 || tx_data == 8'h15); // R3

  AST_QUIET_WHILE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAY || state == ST_SUM) |-> !tx_valid); // R12

  AST_LOCK_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_a_s) |-> $past(lock_a, 2)); // R11
endmodule

bind synth_cmd_responder synth_cmd_responder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .flash_store(flash_store), .lock_a(lock_a),
  .lock_a_s(lock_a_s), .state(state_q));

// File: tb/test_synth_cmd_responder.sv
module test_synth_cmd_responder;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_ready = 1'b1;
  logic lock_a = 1'b0, lock_b = 1'b0;
  logic tx_valid, flash_store;
  logic [7:0] tx_data;

  always #5 clk = ~clk;

  synth_cmd_responder #(.TIMEOUT_CYCLES(TMO)) i_synth_cmd_responder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .lock_a(lock_a), .lock_b(lock_b), .flash_store(flash_store));

  int checks = 0, errors = 0, flashes = 0, cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mdl[92];
  logic       mdl_sel;
  logic [7:0] pay[24];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected reply bytes as the design offers them
  always @(negedge clk) begin
    cyc++;
    if (flash_store) flashes++;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check(0, "R12 unrequested byte", tx_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(tx_data == e, t, tx_data, e);
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic expect_b(logic [7:0] b, string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic send_byte(logic [7:0] b, int gap);
    repeat (gap) @(posedge clk);
    @(posedge clk); #2;
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #2;
    rx_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // kind = opcode bits [2:0]: 0 control words, 1 reference, 2 label, 3 VCO range
  function automatic int base_of(int kind, int ch);
    case (kind)
      0: return ch * 44;
      3: return ch * 44 + 24;
      2: return ch * 44 + 28;
      default: return 88;
    endcase
  endfunction

  function automatic int len_of(int kind);
    case (kind)
      0: return 24;
      2: return 16;
      default: return 4;
    endcase
  endfunction

  task automatic fill(int seed);
    for (int i = 0; i < 24; i++) pay[i] = 8'(seed * 37 + i * 13 + 5);
  endtask

  task automatic rd_mem(int kind, int ch, string t);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < len_of(kind); i++) begin
      expect_b(mdl[base_of(kind, ch) + i], t);
      s = s + mdl[base_of(kind, ch) + i];
    end
    expect_b(s, {t, " checksum"});
    send_byte(8'(8'h80 | kind | (ch << 3)), 0);
    drain();
  endtask

  task automatic wr_mem(int kind, int ch, bit bad, int gap, string t);
    logic [7:0] op, s;
    op = 8'(kind | (ch << 3));
    s = op;
    for (int i = 0; i < len_of(kind); i++) s = s + pay[i];
    expect_b(bad ? 8'h15 : 8'h06, t);
    send_byte(op, 0);
    for (int i = 0; i < len_of(kind); i++) send_byte(pay[i], gap);
    send_byte(bad ? s + 8'h01 : s, gap);
    if (!bad) for (int i = 0; i < len_of(kind); i++) mdl[base_of(kind, ch) + i] = pay[i];
    drain();
  endtask

  task automatic rd_status(string t);
    logic [7:0] sb;
    sb = {2'b00, lock_a, lock_b, 3'b000, mdl_sel};
    expect_b(sb, t);
    expect_b(sb, {t, " checksum"});
    send_byte(8'h86, 0);
    drain();
  endtask

  task automatic wr_sel(logic [7:0] v, bit bad, string t);
    logic [7:0] s;
    s = 8'h06 + v;
    expect_b(bad ? 8'h15 : 8'h06, t);
    send_byte(8'h06, 0);
    send_byte(v, 0);
    send_byte(bad ? s ^ 8'h80 : s, 0);
    if (!bad) mdl_sel = v[0];
    drain();
  endtask

  task automatic unknown_op(logic [7:0] op);
    expect_b(8'h15, "R5 unknown opcode rejected");
    send_byte(op, 0);
    @(negedge clk);
    check(tx_valid == 1'b1, "R5 reject due next cycle", tx_valid, 1);
    drain();
  endtask

  initial begin
    int f0;
    for (int i = 0; i < 92; i++) mdl[i] = 8'h00;
    mdl_sel = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(tx_valid == 1'b0, "R13 tx idle in reset", tx_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_valid == 1'b0, "R13 tx idle after reset", tx_valid, 0);
    check(flash_store == 1'b0, "R13 flash low after reset", flash_store, 0);

    rd_mem(0, 0, "R13 control words zero");
    rd_mem(1, 0, "R13 reference zero");
    rd_status("R13 status zero");

    // R2 first reply byte one cycle after the opcode
    expect_b(8'h00, "R2 first byte");
    for (int i = 1; i < 24; i++) expect_b(8'h00, "R2 data");
    expect_b(8'h00, "R2 checksum");
    send_byte(8'h88, 0);
    @(negedge clk);
    check(tx_valid == 1'b1, "R2 reply due next cycle", tx_valid, 1);
    drain();

    fill(1); wr_mem(0, 0, 0, 0, "R3 write channel A control words");
    rd_mem(0, 0, "R2 read channel A control words");
    rd_mem(0, 1, "R1 channel B untouched");
    fill(2); wr_mem(0, 1, 0, 0, "R1 write channel B control words");
    rd_mem(0, 1, "R1 read channel B");
    rd_mem(0, 0, "R1 channel A kept");

    fill(3); wr_mem(0, 0, 1, 0, "R4 bad checksum rejected");
    rd_mem(0, 0, "R4 store unchanged");

    fill(4); wr_mem(1, 0, 0, 0, "R6 reference write");
    rd_mem(1, 0, "R6 reference read");

    fill(5); wr_mem(3, 0, 0, 0, "R8 VCO A write");
    fill(6); wr_mem(3, 1, 0, 0, "R8 VCO B write");
    fill(7); wr_mem(2, 0, 0, 0, "R8 label A write");
    fill(8); wr_mem(2, 1, 0, 0, "R8 label B write");
    rd_mem(3, 0, "R8 VCO A read");
    rd_mem(3, 1, "R8 VCO B read");
    rd_mem(2, 0, "R8 label A read");
    rd_mem(2, 1, "R8 label B read");
    rd_mem(0, 1, "R8 control words B intact");

    wr_sel(8'h03, 0, "R7 select external");
    rd_status("R7 status select set");
    wr_sel(8'h00, 1, "R4 select bad checksum");
    rd_status("R4 select unchanged");
    @(posedge clk); #2; lock_a = 1'b1;
    repeat (3) @(posedge clk);
    rd_status("R11 lock A reported");
    @(posedge clk); #2; lock_a = 1'b0; lock_b = 1'b1;
    repeat (3) @(posedge clk);
    rd_status("R11 lock B reported");
    wr_sel(8'h02, 0, "R7 select internal from bit 0");
    rd_status("R7 status select clear");

    unknown_op(8'h09);
    unknown_op(8'h0E);
    unknown_op(8'h8E);
    unknown_op(8'hC0);
    unknown_op(8'h05);
    rd_mem(1, 0, "R5 reference unchanged");
    rd_status("R5 select unchanged");

    f0 = flashes;
    expect_b(8'h06, "R9 flash acknowledged");
    send_byte(8'h40, 0);
    send_byte(8'h40, 0);
    @(negedge clk);
    check(flash_store == 1'b1, "R9 flash pulse with ack", flash_store, 1);
    drain();
    check(flashes == f0 + 1, "R9 exactly one pulse cycle", flashes - f0, 1);
    f0 = flashes;
    expect_b(8'h15, "R4 flash bad checksum");
    send_byte(8'h40, 0);
    send_byte(8'h41, 0);
    drain();
    check(flashes == f0, "R4 no flash on bad checksum", flashes - f0, 0);

    // R10 stalled write dropped silently
    send_byte(8'h01, 0);
    send_byte(8'hAA, 0);
    send_byte(8'hBB, 0);
    repeat (TMO + 4) @(negedge clk);
    check(tx_valid == 1'b0, "R10 no reply after timeout", tx_valid, 0);
    rd_mem(1, 0, "R10 reference unchanged after drop");
    fill(9); wr_mem(1, 0, 0, TMO - 4, "R10 gaps below limit accepted");
    rd_mem(1, 0, "R10 slow write stored");

    // R12 backpressure holds the offered byte
    @(posedge clk); #2; tx_ready = 1'b0;
    for (int i = 0; i < 24; i++) expect_b(mdl[i], "R12 read after stall");
    begin
      logic [7:0] s;
      s = 8'h00;
      for (int i = 0; i < 24; i++) s = s + mdl[i];
      expect_b(s, "R12 checksum after stall");
    end
    send_byte(8'h80, 0);
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b1, "R12 valid held", tx_valid, 1);
    check(tx_data == mdl[0], "R12 data held", tx_data, mdl[0]);
    @(posedge clk); #2; tx_ready = 1'b1;
    drain();

    // R12 bytes during a reply are discarded
    f0 = flashes;
    begin
      logic [7:0] s;
      s = 8'h00;
      for (int i = 0; i < 24; i++) begin
        expect_b(mdl[44 + i], "R12 reply while rx busy");
        s = s + mdl[44 + i];
      end
      expect_b(s, "R12 checksum while rx busy");
    end
    send_byte(8'h88, 0);
    send_byte(8'h40, 0);
    send_byte(8'h40, 0);
    drain();
    repeat (10) @(negedge clk);
    check(flashes == f0, "R12 discarded bytes caused no flash", flashes - f0, 0);
    check(exp_q.size() == 0, "R12 all replies seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule